// File: doc/BRIEF.md
# Immediate-Operand Integer Instruction Executor

This block consumes a byte stream of 32-bit integer instructions that each carry a 32-bit immediate operand, and executes them one at a time. It holds eight 32-bit general registers internally and reaches a byte-wide data memory through a simple read/write port.

Two encodings are accepted. A grouped form starts with opcode 0x81, then a ModRM byte, then the immediate. The ModRM byte selects both the operation and the destination. The destination is either a register or the 32-bit memory word addressed by a register. A short form uses a single opcode byte that names the operation, followed directly by the immediate; its destination is always register 0.

Bytes enter one per cycle on a valid/ready handshake. A memory destination is executed as four byte reads, the operation, and then four byte writes. Each instruction ends with either a one-cycle `done` pulse, carrying the value written on `doneData`, or a one-cycle `error` pulse.

Top module: `imm_exec`

## Requirements
- R1: After reset `done` and `error` are 0, `inReady` is 1, and every register reads as zero.
- R2: For opcode 0x81 with ModRM bits 7:6 = 11, the register numbered by ModRM bits 2:0 is replaced by (register op immediate). ModRM bits 5:3 pick the operation: 0 add, 1 OR, 4 AND, 5 subtract, 6 XOR. The new value appears on `doneData` while `done` is high.
- R3: The four immediate bytes are taken least significant first, so bytes 0a 0b 0c 0d form 0x0d0c0b0a.
- R4: The single-byte opcodes 0x2D (subtract), 0x25 (AND), 0x0D (OR) and 0x35 (XOR) are followed directly by the immediate and always update register 0.
- R5: For opcode 0x81 with ModRM bits 7:6 = 00, the destination is the little-endian word at addresses A..A+3, where A is the low `ADDR_W` bits of the register named by ModRM bits 2:0. The block reads all four bytes, then writes the four result bytes back to the same addresses, and raises `done` only after the last write.
- R6: Add and subtract wrap modulo 2^32.
- R7: Under opcode 0x81, ModRM bits 5:3 values 2, 3 and 7 are rejected. The four immediate bytes are still consumed, `error` pulses, and no register or memory byte changes.
- R8: Under opcode 0x81, ModRM bits 7:6 = 01 or 10 are rejected, and so are bits 7:6 = 00 with bits 2:0 = 4 or 5. In each case the block consumes the immediate, pulses `error`, issues no memory access and changes no register.
- R9: Any other opcode byte pulses `error` one cycle after it is accepted, and the next byte is decoded as a new opcode.
- R10: `inReady` is low while memory is accessed; `memRd` and `memWr` are never high together; read data is taken on `memRdData` the cycle after `memRd`.
- R11: `done` and `error` last exactly one cycle and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inByte | input | 8 | Instruction stream byte |
| inValid | input | 1 | `inByte` holds a byte |
| inReady | output | 1 | Block accepts a byte this cycle |
| memAddr | output | ADDR_W | Byte address for a read or a write |
| memRd | output | 1 | Read strobe; data is expected on the next cycle |
| memWr | output | 1 | Write strobe |
| memWrData | output | 8 | Byte to write |
| memRdData | input | 8 | Byte returned one cycle after `memRd` |
| done | output | 1 | One-cycle pulse when an instruction completes |
| error | output | 1 | One-cycle pulse when an instruction is rejected |
| doneData | output | 32 | Value written by the last completed instruction |

## Verification
Each of the five grouped operations is applied to a register with operand values whose bytes all differ. A swapped immediate byte or a wrong operation selector therefore gives a distinct result. The four short opcodes are run on register 0 with the same operand sets, which separates opcode-driven selection from ModRM-driven selection. Memory-destination runs use words with four different bytes and compare the memory image byte by byte, which exposes byte order, address stepping and write-before-read ordering. Rejected ModRM fields and opcodes are followed by register and memory reads that would reveal any stray update, and by a valid instruction that confirms the stream realigns.

// File: rtl/imm_exec_pkg.sv
package imm_exec_pkg;

  localparam int WORD_W     = 32;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int IDX_W      = $clog2(WORD_BYTES);
  localparam int NUM_REGS   = 8;
  localparam int REG_W      = $clog2(NUM_REGS);

  localparam logic [7:0] OPC_GROUP  = 8'h81;
  localparam logic [7:0] OPC_SUB_R0 = 8'h2D;
  localparam logic [7:0] OPC_AND_R0 = 8'h25;
  localparam logic [7:0] OPC_OR_R0  = 8'h0D;
  localparam logic [7:0] OPC_XOR_R0 = 8'h35;

  // Values equal the ModRM bits 5:3 operation field
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_OR   = 3'd1,
    OP_RSV2 = 3'd2,
    OP_RSV3 = 3'd3,
    OP_AND  = 3'd4,
    OP_SUB  = 3'd5,
    OP_XOR  = 3'd6,
    OP_RSV7 = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic             immShift;
    logic             regWrite;
    logic             wordLoad;
    logic             resultLatch;
    logic             destMem;
    logic [REG_W-1:0] regSel;
    alu_op_e          op;
    logic [IDX_W-1:0] byteIdx;
  } ctrl_strobe_t;

endpackage

// File: rtl/imm_exec_alu.sv
module imm_exec_alu
  import imm_exec_pkg::*;
(
  input  alu_op_e           op,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic [WORD_W-1:0] res
);

  always_comb begin
    unique case (op)
      OP_ADD:  res = opA + opB;
      OP_SUB:  res = opA - opB;
      OP_AND:  res = opA & opB;
      OP_OR:   res = opA | opB;
      OP_XOR:  res = opA ^ opB;
      default: res = opA;
    endcase
  end

endmodule

// File: rtl/imm_exec_dp.sv
module imm_exec_dp
  import imm_exec_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobe,
  input  logic [7:0]        inByte,
  input  logic [7:0]        memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWrData,
  output logic [WORD_W-1:0] doneData
);

  logic [WORD_W-1:0] regFile [NUM_REGS];
  logic [WORD_W-1:0] immQ;
  logic [WORD_W-1:0] memWordQ;
  logic [WORD_W-1:0] resultQ;
  logic [WORD_W-1:0] opA;
  logic [WORD_W-1:0] aluRes;

  assign opA = strobe.destMem ? memWordQ : regFile[strobe.regSel];

  imm_exec_alu alu_i (
    .op  (strobe.op),
    .opA (opA),
    .opB (immQ),
    .res (aluRes)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        regFile[g] <= '0;
      end else if (strobe.regWrite && (strobe.regSel == REG_W'(g))) begin
        regFile[g] <= aluRes;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      immQ     <= '0;
      memWordQ <= '0;
      resultQ  <= '0;
    end else begin
      if (strobe.immShift) immQ <= {inByte, immQ[WORD_W-1:8]};
      if (strobe.wordLoad) memWordQ[strobe.byteIdx*8 +: 8] <= memRdData;
      if (strobe.resultLatch) resultQ <= aluRes;
    end
  end

  assign memAddr   = regFile[strobe.regSel][ADDR_W-1:0] + ADDR_W'(strobe.byteIdx);
  assign memWrData = aluRes[strobe.byteIdx*8 +: 8];
  assign doneData  = resultQ;

  // R3: each accepted immediate byte enters at the top and moves down
  a_r3_imm_top_byte: assert property (@(posedge clk) disable iff (!rstN)
    strobe.immShift |=> immQ[WORD_W-1 -: 8] == $past(inByte));

  // R5: a captured read byte lands in the word lane picked by the index
  a_r5_word_lane: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wordLoad && strobe.byteIdx == '0) |=> memWordQ[7:0] == $past(memRdData));

endmodule

// File: rtl/imm_exec_ctrl.sv
module imm_exec_ctrl
  import imm_exec_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [7:0]   inByte,
  input  logic         inValid,
  output logic         inReady,
  output logic         memRd,
  output logic         memWr,
  output logic         done,
  output logic         error,
  output ctrl_strobe_t strobe
);

  typedef enum logic [2:0] {
    S_OPC, S_MODRM, S_IMM, S_REGWB, S_RDREQ, S_RDCAP, S_WR
  } state_e;

  state_e           stateQ;
  alu_op_e          opQ;
  logic [REG_W-1:0] destRegQ;
  logic             destMemQ;
  logic             badQ;
  logic [IDX_W-1:0] cntQ;
  logic             doneQ;
  logic             errorQ;
  logic             cntLast;

  logic [1:0]       modF;
  logic [2:0]       subF;
  logic [REG_W-1:0] rmF;
  logic             subOk;
  logic             modOk;

  assign modF    = inByte[7:6];
  assign subF    = inByte[5:3];
  assign rmF     = inByte[2:0];
  assign subOk   = (subF == 3'd0) || (subF == 3'd1) || (subF == 3'd4) ||
                   (subF == 3'd5) || (subF == 3'd6);
  assign modOk   = (modF == 2'b11) ||
                   ((modF == 2'b00) && (rmF != 3'd4) && (rmF != 3'd5));
  assign cntLast = (cntQ == IDX_W'(WORD_BYTES - 1));

  assign inReady = (stateQ == S_OPC) || (stateQ == S_MODRM) || (stateQ == S_IMM);
  assign memRd   = (stateQ == S_RDREQ);
  assign memWr   = (stateQ == S_WR);
  assign done    = doneQ;
  assign error   = errorQ;

  always_comb begin
    strobe             = '0;
    strobe.immShift    = (stateQ == S_IMM) && inValid;
    strobe.regWrite    = (stateQ == S_REGWB);
    strobe.wordLoad    = (stateQ == S_RDCAP);
    strobe.resultLatch = (stateQ == S_REGWB) || ((stateQ == S_WR) && cntLast);
    strobe.destMem     = destMemQ;
    strobe.regSel      = destRegQ;
    strobe.op          = opQ;
    strobe.byteIdx     = cntQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= S_OPC;
      opQ      <= OP_ADD;
      destRegQ <= '0;
      destMemQ <= 1'b0;
      badQ     <= 1'b0;
      cntQ     <= '0;
      doneQ    <= 1'b0;
      errorQ   <= 1'b0;
    end else begin
      doneQ  <= 1'b0;
      errorQ <= 1'b0;
      unique case (stateQ)
        S_OPC: begin
          if (inValid) begin
            destRegQ <= '0;
            destMemQ <= 1'b0;
            badQ     <= 1'b0;
            cntQ     <= '0;
            unique case (inByte)
              OPC_GROUP:  stateQ <= S_MODRM;
              OPC_SUB_R0: begin opQ <= OP_SUB; stateQ <= S_IMM; end
              OPC_AND_R0: begin opQ <= OP_AND; stateQ <= S_IMM; end
              OPC_OR_R0:  begin opQ <= OP_OR;  stateQ <= S_IMM; end
              OPC_XOR_R0: begin opQ <= OP_XOR; stateQ <= S_IMM; end
              default:    errorQ <= 1'b1;
            endcase
          end
        end
        S_MODRM: begin
          if (inValid) begin
            opQ      <= alu_op_e'(subF);
            destRegQ <= rmF;
            destMemQ <= (modF == 2'b00);
            badQ     <= !(subOk && modOk);
            stateQ   <= S_IMM;
          end
        end
        S_IMM: begin
          if (inValid) begin
            cntQ <= cntQ + 1'b1;
            if (cntLast) begin
              if (badQ) begin
                errorQ <= 1'b1;
                stateQ <= S_OPC;
              end else if (destMemQ) begin
                stateQ <= S_RDREQ;
              end else begin
                stateQ <= S_REGWB;
              end
            end
          end
        end
        S_REGWB: begin
          doneQ  <= 1'b1;
          stateQ <= S_OPC;
        end
        S_RDREQ: stateQ <= S_RDCAP;
        S_RDCAP: begin
          cntQ   <= cntQ + 1'b1;
          stateQ <= cntLast ? S_WR : S_RDREQ;
        end
        S_WR: begin
          cntQ <= cntQ + 1'b1;
          if (cntLast) begin
            doneQ  <= 1'b1;
            stateQ <= S_OPC;
          end
        end
        default: stateQ <= S_OPC;
      endcase
    end
  end

  // R10: read and write strobes are exclusive
  a_r10_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

  // R10: no byte is accepted while memory is being accessed
  a_r10_no_accept_in_mem: assert property (@(posedge clk) disable iff (!rstN)
    (memRd || memWr) |-> !inReady);

  // R11: completion and rejection never coincide
  a_r11_done_err_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error));

  // R11: done is a single-cycle pulse
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: a rejection is never preceded by a state update
  a_r7_err_no_update: assert property (@(posedge clk) disable iff (!rstN)
    error |-> $past(!strobe.regWrite && !memWr));

  // R8: a rejected memory form issues no read
  a_r8_bad_no_read: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> !badQ);

endmodule

// File: rtl/imm_exec.sv
module imm_exec
  import imm_exec_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        inByte,
  input  logic              inValid,
  output logic              inReady,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  output logic [7:0]        memWrData,
  input  logic [7:0]        memRdData,
  output logic              done,
  output logic              error,
  output logic [31:0]       doneData
);

  ctrl_strobe_t strobe;

  imm_exec_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .inByte  (inByte),
    .inValid (inValid),
    .inReady (inReady),
    .memRd   (memRd),
    .memWr   (memWr),
    .done    (done),
    .error   (error),
    .strobe  (strobe)
  );

  imm_exec_dp #(.ADDR_W(ADDR_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .inByte    (inByte),
    .memRdData (memRdData),
    .memAddr   (memAddr),
    .memWrData (memWrData),
    .doneData  (doneData)
  );

endmodule

// File: tb/imm_exec_tb_top.sv
`timescale 1ns/1ps
module imm_exec_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  inByte = '0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [7:0]  memAddr;
  logic        memRd, memWr;
  logic [7:0]  memWrData;
  logic [7:0]  memRdData = '0;
  logic        done, error;
  logic [31:0] doneData;

  int checks = 0;
  int errors = 0;
  int wrCnt = 0;
  int rdCnt = 0;
  int cycles = 0;
  logic [7:0] mem [256];

  always #2 clk = ~clk;

  imm_exec #(.ADDR_W(8)) dut_i (
    .clk(clk), .rstN(rstN), .inByte(inByte), .inValid(inValid), .inReady(inReady),
    .memAddr(memAddr), .memRd(memRd), .memWr(memWr), .memWrData(memWrData),
    .memRdData(memRdData), .done(done), .error(error), .doneData(doneData)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (memWr) begin
      mem[memAddr] <= memWrData;
      wrCnt <= wrCnt + 1;
    end
    if (memRd) begin
      memRdData <= mem[memAddr];
      rdCnt <= rdCnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    while (!inReady) @(negedge clk);
    inValid = 1'b1;
    inByte  = b;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic sendImm(input logic [31:0] v);
    for (int i = 0; i < 4; i++) sendByte(v[i*8 +: 8]);
  endtask

  task automatic waitEnd(output bit d, output bit e, output logic [31:0] r, output int wrAtEnd);
    bit seen = 1'b0;
    d = 1'b0; e = 1'b0; r = '0; wrAtEnd = 0;
    for (int i = 0; i < 40; i++) begin
      if (!seen) begin
        if (done || error) begin
          d = done; e = error; r = doneData; wrAtEnd = wrCnt;
          seen = 1'b1;
          @(negedge clk);
          chk(!(done || error), "R11 pulse width", {31'b0, done | error}, 32'd0);
        end else begin
          @(negedge clk);
        end
      end
    end
  endtask

  task automatic runGroup(input logic [7:0] modrm, input logic [31:0] imm,
                          output bit d, output bit e, output logic [31:0] r, output int wrAtEnd);
    sendByte(8'h81);
    sendByte(modrm);
    sendImm(imm);
    waitEnd(d, e, r, wrAtEnd);
  endtask

  task automatic runShort(input logic [7:0] opc, input logic [31:0] imm,
                          output bit d, output bit e, output logic [31:0] r);
    int w;
    sendByte(opc);
    sendImm(imm);
    waitEnd(d, e, r, w);
  endtask

  task automatic readReg(input int n, output logic [31:0] v);
    bit d, e; int w;
    runGroup(8'hC8 | 8'(n), 32'h0, d, e, v, w);
  endtask

  task automatic setReg(input int n, input logic [31:0] v);
    bit d, e; int w; logic [31:0] cur, r;
    readReg(n, cur);
    runGroup(8'hF0 | 8'(n), cur ^ v, d, e, r, w);
  endtask

  task automatic testReset();
    logic [31:0] v;
    chk(done == 1'b0 && error == 1'b0, "R1 outputs idle", {30'b0, done, error}, 32'd0);
    chk(inReady == 1'b1, "R1 ready", {31'b0, inReady}, 32'd1);
    readReg(5, v);
    chk(v == 32'h0, "R1 register zero", v, 32'h0);
  endtask

  task automatic regCase(input string tag, input int n, input logic [31:0] init,
                         input logic [7:0] modrm, input logic [31:0] imm, input logic [31:0] exp);
    bit d, e; int w; logic [31:0] r, rb;
    setReg(n, init);
    runGroup(modrm, imm, d, e, r, w);
    chk(d && !e, {tag, " done"}, {31'b0, d}, 32'd1);
    chk(r == exp, {tag, " result"}, r, exp);
    readReg(n, rb);
    chk(rb == exp, {tag, " register"}, rb, exp);
  endtask

  task automatic testRegForms();
    regCase("R2 R3 add", 3, 32'h1,        8'hC3, 32'h0d0c0b0a, 32'h0d0c0b0b);
    regCase("R2 sub",    3, 32'd10,       8'hEB, 32'h1,        32'h9);
    regCase("R2 and",    3, 32'hff,       8'hE3, 32'h0d0c0b0a, 32'h0000000a);
    regCase("R2 or",     6, 32'hd0c0b0a0, 8'hCE, 32'h0d0c0b0a, 32'hddccbbaa);
    regCase("R2 xor",    7, 32'hddccb0a0, 8'hF7, 32'h0d0c0b0a, 32'hd0c0bbaa);
  endtask

  task automatic shortCase(input string tag, input logic [31:0] init,
                           input logic [7:0] opc, input logic [31:0] imm, input logic [31:0] exp);
    bit d, e; logic [31:0] r, other;
    setReg(1, 32'h12345678);
    setReg(0, init);
    runShort(opc, imm, d, e, r);
    chk(d && !e && r == exp, {tag, " result"}, r, exp);
    readReg(1, other);
    chk(other == 32'h12345678, {tag, " other register untouched"}, other, 32'h12345678);
  endtask

  task automatic testShortForms();
    shortCase("R4 sub", 32'h0d0c0baa, 8'h2D, 32'h0d0c0b0a, 32'h000000a0);
    shortCase("R4 and", 32'h000000ff, 8'h25, 32'h0d0c0b0a, 32'h0000000a);
    shortCase("R4 or",  32'hd0c0b0a0, 8'h0D, 32'h0d0c0b0a, 32'hddccbbaa);
    shortCase("R4 xor", 32'hddccb0a0, 8'h35, 32'h0d0c0b0a, 32'hd0c0bbaa);
  endtask

  task automatic testWrap();
    regCase("R6 add wrap", 2, 32'hffffffff, 8'hC2, 32'h2, 32'h1);
    shortCase("R6 sub wrap", 32'h0, 8'h2D, 32'h1, 32'hffffffff);
  endtask

  task automatic memCase(input string tag, input logic [7:0] modrm, input logic [31:0] init,
                         input logic [31:0] imm, input logic [31:0] exp);
    bit d, e; int w; logic [31:0] r, img;
    setReg(3, 32'h60);
    for (int i = 0; i < 4; i++) mem[8'h60 + i] = init[i*8 +: 8];
    mem[8'h64] = 8'h5a;
    @(negedge clk);
    wrCnt = 0; rdCnt = 0;
    runGroup(modrm, imm, d, e, r, w);
    for (int i = 0; i < 4; i++) img[i*8 +: 8] = mem[8'h60 + i];
    chk(d && !e && r == exp, {tag, " done value"}, r, exp);
    chk(img == exp, {tag, " memory word"}, img, exp);
    chk(w == 4, {tag, " done after 4 writes"}, w, 32'd4);
    chk(rdCnt == 4, {tag, " R10 four reads"}, rdCnt, 32'd4);
    chk(mem[8'h64] == 8'h5a, {tag, " neighbour byte"}, {24'b0, mem[8'h64]}, 32'h5a);
  endtask

  task automatic testMemForms();
    memCase("R5 add", 8'h03, 32'h00000001, 32'h0d0c0b0a, 32'h0d0c0b0b);
    memCase("R5 sub", 8'h2B, 32'd10,       32'h1,        32'h9);
    memCase("R5 or",  8'h0B, 32'hd0c0b0a0, 32'h0d0c0b0a, 32'hddccbbaa);
    memCase("R5 xor", 8'h33, 32'hd0c0b0a0, 32'h0d0c0b0a, 32'hddccbbaa);
    memCase("R5 and", 8'h23, 32'h000000ff, 32'h0d0c0b0a, 32'h0000000a);
  endtask

  task automatic badCase(input string tag, input logic [7:0] modrm);
    bit d, e; int w; logic [31:0] r, v3, img;
    setReg(3, 32'h60);
    for (int i = 0; i < 4; i++) mem[8'h60 + i] = 8'h11 * 8'(i + 1);
    @(negedge clk);
    wrCnt = 0; rdCnt = 0;
    runGroup(modrm, 32'h0d0c0b0a, d, e, r, w);
    chk(e && !d, {tag, " error pulse"}, {30'b0, d, e}, 32'd1);
    chk(wrCnt == 0 && rdCnt == 0, {tag, " no memory access"}, wrCnt + rdCnt, 32'd0);
    for (int i = 0; i < 4; i++) img[i*8 +: 8] = mem[8'h60 + i];
    chk(img == 32'h44332211, {tag, " memory unchanged"}, img, 32'h44332211);
    readReg(3, v3);
    chk(v3 == 32'h60, {tag, " register unchanged"}, v3, 32'h60);
  endtask

  task automatic testBadSub();
    badCase("R7 sub2 reg", 8'hD3);
    badCase("R7 sub3 reg", 8'hDB);
    badCase("R7 sub7 mem", 8'h3B);
  endtask

  task automatic testBadAddr();
    badCase("R8 mod01", 8'h43);
    badCase("R8 mod10", 8'h83);
    badCase("R8 rm4",   8'h04);
    badCase("R8 rm5",   8'h05);
  endtask

  task automatic testBadOpcode();
    bit d, e; int w; logic [31:0] r;
    setReg(0, 32'hcafe0001);
    sendByte(8'h90);
    waitEnd(d, e, r, w);
    chk(e && !d, "R9 unknown opcode error", {30'b0, d, e}, 32'd1);
    runShort(8'h0D, 32'h0, d, e, r);
    chk(d && !e && r == 32'hcafe0001, "R9 realigned after error", r, 32'hcafe0001);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegForms();
    testShortForms();
    testWrap();
    testMemForms();
    testBadSub();
    testBadAddr();
    testBadOpcode();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles >= 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule